// File: doc/BRIEF.md
# Scoreboard Issue Unit

This block sits between instruction decode and three execution pipes. It holds up to eight decoded instructions in a queue kept in program order. Each cycle it picks every instruction that can safely leave and routes it to one of three downstream FIFOs: memory (load/store), integer ALU, and multiply. The oldest queued instruction always sits in slot 0.

Selection may be out of order. A younger instruction can pass an older one that is blocked, as long as no register or memory-ordering hazard exists between them. Each FIFO is two entries deep. At most two instructions go to one class in a cycle, so at most six leave per cycle.

A per-register pending bitmap records destinations whose producers have issued but not yet written back. Writeback ports clear bits at the clock edge.

Decode appends new instructions at the tail. It may only send as many as the queue had free at the start of the cycle. Issued entries are removed in the same edge, and the survivors close ranks in age order.

Top module: `scoreboard_issue`

## Requirements
- R1: After reset the queue is empty (`q_count` = 0), no issue slot is valid and no register is pending. Each cycle `in_cnt` new words are appended at the tail, in fetch-slot order, and `in_cnt` never exceeds the free entries at the start of the cycle.
- R2: Instruction word layout:
  - bits [26:25] class: 0 memory, 1 ALU, 2 multiply, 3 never issues.
  - bit [24] store flag: memory class only, 0 means load.
  - bit [23] destination valid; bits [22:18] destination.
  - bit [17] source-1 valid; bits [16:12] source 1.
  - bit [11] source-2 valid; bits [10:6] source 2.
  - bits [5:0] tag.
  
  An issued word appears unchanged on the slot outputs of its own class only.
- R3: Per class, the number issued in a cycle is at most 2 minus that FIFO's occupancy sampled in the same cycle. Eligible entries are taken oldest first, up to six in total.
- R4: An entry does not issue while a source it reads is the destination of any older queued entry, or is pending.
- R5: An entry does not issue while its destination equals the destination of any older queued entry, or is pending.
- R6: An entry does not issue while its destination equals a source read by any older queued entry.
- R7: Issuing an entry with a valid destination marks that register pending from the next cycle on. A writeback of the register clears the mark at the clock edge, so the clear first unblocks consumers in the following cycle.
- R8: A load does not issue while any older store remains unissued. A load may issue in the same cycle as the older stores if those stores also issue.
- R9: Stores issue in program order. A store may issue ahead of an older, unissued load.
- R10: Issued entries are removed at the clock edge and the rest shift down in age order, so `q_count` becomes count − issued + appended. Within a class, slot 0 carries the older of two issued instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_cnt | input | 3 | Number of words appended this cycle (0..4) |
| in_instr | input | 108 | Four instruction words; word k at bits [27k+26:27k] |
| occ_mem | input | 2 | Memory FIFO occupancy at start of cycle |
| occ_alu | input | 2 | ALU FIFO occupancy at start of cycle |
| occ_mul | input | 2 | Multiply FIFO occupancy at start of cycle |
| wb_vld | input | 3 | Writeback port valid flags |
| wb_reg | input | 15 | Writeback register numbers, 5 bits per port |
| q_count | output | 4 | Queue entries held |
| mem_vld | output | 2 | Memory issue slot valid |
| mem_instr | output | 54 | Memory issue slot words |
| alu_vld | output | 2 | ALU issue slot valid |
| alu_instr | output | 54 | ALU issue slot words |
| mul_vld | output | 2 | Multiply issue slot valid |
| mul_instr | output | 54 | Multiply issue slot words |

## Verification
The bench builds the block at its default parameters: an eight-entry queue, four-wide append, two-entry output FIFOs and three writeback ports. That configuration is small enough to sweep every class against every FIFO occupancy (0, 1 and 2) with a full queue, so the per-class cap and the oldest-first order are checked at every value they can take. Directed queue contents then reach each hazard kind singly, the store/load ordering corners, the one-cycle delay of a writeback clear, and the shift-down of survivors across consecutive cycles.

// File: rtl/issue_pkg.sv
`timescale 1ns/1ps
package issue_pkg;
    localparam int REG_W   = 5;
    localparam int TAG_W   = 6;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_MEM  = 2'd0,
        CLS_ALU  = 2'd1,
        CLS_MUL  = 2'd2,
        CLS_NONE = 2'd3
    } op_cls_e;

    typedef struct packed {
        op_cls_e            cls;
        logic               store;
        logic               dst_v;
        logic [REG_W-1:0]   dst;
        logic               s1_v;
        logic [REG_W-1:0]   s1;
        logic               s2_v;
        logic [REG_W-1:0]   s2;
        logic [TAG_W-1:0]   tag;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/issue_queue.sv
`timescale 1ns/1ps
module issue_queue
    import issue_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int FETCH_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(FETCH_W+1)-1:0] in_cnt,
    input  instr_t                       in_word [FETCH_W],
    input  logic [DEPTH-1:0]             take,
    output instr_t                       q       [DEPTH],
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CNT_W = $clog2(DEPTH+1);

    instr_t            nxt_q [DEPTH];
    logic [CNT_W-1:0]  nxt_count;
    int                wr;

    // Survivors keep their relative order; new words land behind them.
    always_comb begin
        wr = 0;
        for (int k = 0; k < DEPTH; k++) nxt_q[k] = q[k];
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count) && !take[i]) begin
                for (int k = 0; k < DEPTH; k++)
                    if (k == wr) nxt_q[k] = q[i];
                wr = wr + 1;
            end
        end
        for (int j = 0; j < FETCH_W; j++) begin
            if (j < int'(in_cnt)) begin
                for (int k = 0; k < DEPTH; k++)
                    if (k == wr) nxt_q[k] = in_word[j];
                wr = wr + 1;
            end
        end
        nxt_count = (wr > DEPTH) ? CNT_W'(DEPTH) : CNT_W'(wr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int k = 0; k < DEPTH; k++) q[k] <= '0;
        end else begin
            count <= nxt_count;
            for (int k = 0; k < DEPTH; k++) q[k] <= nxt_q[k];
        end
    end

    a_r1_append_room: assert property (@(posedge clk) disable iff (!rst_n)
        int'(in_cnt) <= DEPTH - int'(count));
endmodule

// File: rtl/issue_hazard.sv
`timescale 1ns/1ps
module issue_hazard
    import issue_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NREG  = 32
) (
    input  instr_t                     q      [DEPTH],
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [NREG-1:0]            pend,
    output logic [DEPTH-1:0]           haz_ok
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            haz_ok[i] = (i < int'(count));
            // registers still owed by an issued producer
            if (q[i].s1_v  && pend[q[i].s1])  haz_ok[i] = 1'b0;
            if (q[i].s2_v  && pend[q[i].s2])  haz_ok[i] = 1'b0;
            if (q[i].dst_v && pend[q[i].dst]) haz_ok[i] = 1'b0;
            // every older entry, whether it leaves this cycle or not
            for (int j = 0; j < i; j++) begin
                if (q[j].dst_v && q[i].s1_v && q[i].s1 == q[j].dst) haz_ok[i] = 1'b0;
                if (q[j].dst_v && q[i].s2_v && q[i].s2 == q[j].dst) haz_ok[i] = 1'b0;
                if (q[j].dst_v && q[i].dst_v && q[i].dst == q[j].dst) haz_ok[i] = 1'b0;
                if (q[i].dst_v && q[j].s1_v && q[j].s1 == q[i].dst) haz_ok[i] = 1'b0;
                if (q[i].dst_v && q[j].s2_v && q[j].s2 == q[i].dst) haz_ok[i] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/issue_select.sv
`timescale 1ns/1ps
module issue_select
    import issue_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int OQ_DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  instr_t                        q        [DEPTH],
    input  logic [$clog2(DEPTH+1)-1:0]    count,
    input  logic [DEPTH-1:0]              haz_ok,
    input  logic [$clog2(OQ_DEPTH+1)-1:0] occ      [NUM_CLS],
    output logic [DEPTH-1:0]              take,
    output logic [OQ_DEPTH-1:0]           slot_vld [NUM_CLS],
    output instr_t                        slot_ins [NUM_CLS][OQ_DEPTH]
);
    int     free_c  [NUM_CLS];
    int     cls_cnt [NUM_CLS];
    logic   store_open;
    logic   go;
    instr_t ent;

    always_comb begin
        for (int c = 0; c < NUM_CLS; c++)
            free_c[c] = (int'(occ[c]) >= OQ_DEPTH) ? 0 : OQ_DEPTH - int'(occ[c]);
    end

    // Walk from oldest to newest; a store left behind closes memory issue.
    always_comb begin
        take       = '0;
        store_open = 1'b0;
        go         = 1'b0;
        ent        = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            cls_cnt[c]  = 0;
            slot_vld[c] = '0;
            for (int k = 0; k < OQ_DEPTH; k++) slot_ins[c][k] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            ent = q[i];
            go  = 1'b0;
            for (int c = 0; c < NUM_CLS; c++) begin
                if (int'(ent.cls) == c && haz_ok[i] && cls_cnt[c] < free_c[c] &&
                    !(c == int'(CLS_MEM) && store_open)) begin
                    go = 1'b1;
                    for (int k = 0; k < OQ_DEPTH; k++) begin
                        if (cls_cnt[c] == k) begin
                            slot_vld[c][k] = 1'b1;
                            slot_ins[c][k] = ent;
                        end
                    end
                    cls_cnt[c] = cls_cnt[c] + 1;
                end
            end
            take[i] = go;
            if (!go && i < int'(count) && ent.cls == CLS_MEM && ent.store)
                store_open = 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_chk
        a_r3_class_cap: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(slot_vld[c]) <= free_c[c]);
        a_r10_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_vld[c] & (slot_vld[c] + OQ_DEPTH'(1))) == '0);
    end
endmodule

// File: rtl/issue_scoreboard.sv
`timescale 1ns/1ps
module issue_scoreboard
    import issue_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int WB_PORTS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NREG-1:0]     set_vec,
    input  logic [WB_PORTS-1:0] wb_vld,
    input  logic [REG_W-1:0]    wb_r [WB_PORTS],
    output logic [NREG-1:0]     pend
);
    logic [NREG-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < WB_PORTS; p++)
            if (wb_vld[p]) clr_vec[wb_r[p]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_vec) | set_vec;
    end

    for (genvar p = 0; p < WB_PORTS; p++) begin : g_wb
        a_r7_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_vld[p] && !set_vec[wb_r[p]]) |=> !pend[$past(wb_r[p])]);
    end
endmodule

// File: rtl/scoreboard_issue.sv
`timescale 1ns/1ps
module scoreboard_issue
    import issue_pkg::*;
#(
    parameter int QDEPTH   = 8,
    parameter int FETCH_W  = 4,
    parameter int OQ_DEPTH = 2,
    parameter int WB_PORTS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(FETCH_W+1)-1:0]     in_cnt,
    input  logic [FETCH_W*INSTR_W-1:0]       in_instr,
    input  logic [$clog2(OQ_DEPTH+1)-1:0]    occ_mem,
    input  logic [$clog2(OQ_DEPTH+1)-1:0]    occ_alu,
    input  logic [$clog2(OQ_DEPTH+1)-1:0]    occ_mul,
    input  logic [WB_PORTS-1:0]              wb_vld,
    input  logic [WB_PORTS*REG_W-1:0]        wb_reg,
    output logic [$clog2(QDEPTH+1)-1:0]      q_count,
    output logic [OQ_DEPTH-1:0]              mem_vld,
    output logic [OQ_DEPTH*INSTR_W-1:0]      mem_instr,
    output logic [OQ_DEPTH-1:0]              alu_vld,
    output logic [OQ_DEPTH*INSTR_W-1:0]      alu_instr,
    output logic [OQ_DEPTH-1:0]              mul_vld,
    output logic [OQ_DEPTH*INSTR_W-1:0]      mul_instr
);
    localparam int NREG  = 1 << REG_W;
    localparam int OCC_W = $clog2(OQ_DEPTH+1);

    instr_t             in_word  [FETCH_W];
    instr_t             q        [QDEPTH];
    logic [QDEPTH-1:0]  haz_ok;
    logic [QDEPTH-1:0]  take;
    logic [NREG-1:0]    pend;
    logic [NREG-1:0]    set_vec;
    logic [OCC_W-1:0]   occ      [NUM_CLS];
    logic [OQ_DEPTH-1:0] slot_vld [NUM_CLS];
    instr_t             slot_ins [NUM_CLS][OQ_DEPTH];
    logic [REG_W-1:0]   wb_r     [WB_PORTS];

    for (genvar j = 0; j < FETCH_W; j++) begin : g_in
        assign in_word[j] = instr_t'(in_instr[j*INSTR_W +: INSTR_W]);
    end
    for (genvar p = 0; p < WB_PORTS; p++) begin : g_wbr
        assign wb_r[p] = wb_reg[p*REG_W +: REG_W];
    end

    assign occ[0] = occ_mem;
    assign occ[1] = occ_alu;
    assign occ[2] = occ_mul;

    issue_queue #(.DEPTH(QDEPTH), .FETCH_W(FETCH_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_word(in_word),
        .take(take), .q(q), .count(q_count)
    );

    issue_hazard #(.DEPTH(QDEPTH), .NREG(NREG)) u_hazard (
        .q(q), .count(q_count), .pend(pend), .haz_ok(haz_ok)
    );

    issue_select #(.DEPTH(QDEPTH), .OQ_DEPTH(OQ_DEPTH)) u_select (
        .clk(clk), .rst_n(rst_n), .q(q), .count(q_count), .haz_ok(haz_ok),
        .occ(occ), .take(take), .slot_vld(slot_vld), .slot_ins(slot_ins)
    );

    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NUM_CLS; c++)
            for (int k = 0; k < OQ_DEPTH; k++)
                if (slot_vld[c][k] && slot_ins[c][k].dst_v)
                    set_vec[slot_ins[c][k].dst] = 1'b1;
    end

    issue_scoreboard #(.NREG(NREG), .WB_PORTS(WB_PORTS)) u_sb (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wb_vld(wb_vld),
        .wb_r(wb_r), .pend(pend)
    );

    assign mem_vld = slot_vld[0];
    assign alu_vld = slot_vld[1];
    assign mul_vld = slot_vld[2];
    for (genvar k = 0; k < OQ_DEPTH; k++) begin : g_out
        assign mem_instr[k*INSTR_W +: INSTR_W] = slot_ins[0][k];
        assign alu_instr[k*INSTR_W +: INSTR_W] = slot_ins[1][k];
        assign mul_instr[k*INSTR_W +: INSTR_W] = slot_ins[2][k];
    end

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_chk
        for (genvar k = 0; k < OQ_DEPTH; k++) begin : g_slot
            a_r5_dst_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_vld[c][k] && slot_ins[c][k].dst_v) |-> !pend[slot_ins[c][k].dst]);
            a_r4_src_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
                slot_vld[c][k] |-> !((slot_ins[c][k].s1_v && pend[slot_ins[c][k].s1]) ||
                                     (slot_ins[c][k].s2_v && pend[slot_ins[c][k].s2])));
        end
    end
endmodule

// File: tb/sim_scoreboard_issue.sv
`timescale 1ns/1ps
module sim_scoreboard_issue;
    import issue_pkg::*;
    localparam int QD = 8, FW = 4, OQ = 2, WBP = 3, W = INSTR_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic [2:0] in_cnt = '0;
    logic [FW*W-1:0] in_instr = '0;
    logic [1:0] occ_mem = 2'd2, occ_alu = 2'd2, occ_mul = 2'd2;
    logic [WBP-1:0] wb_vld = '0;
    logic [WBP*5-1:0] wb_reg = '0;
    logic [3:0] q_count;
    logic [OQ-1:0] mem_vld, alu_vld, mul_vld;
    logic [OQ*W-1:0] mem_instr, alu_instr, mul_instr;

    scoreboard_issue #(.QDEPTH(QD), .FETCH_W(FW), .OQ_DEPTH(OQ), .WB_PORTS(WBP)) u0 (
        .clk(clk), .rst_n(rst_n), .in_cnt(in_cnt), .in_instr(in_instr),
        .occ_mem(occ_mem), .occ_alu(occ_alu), .occ_mul(occ_mul),
        .wb_vld(wb_vld), .wb_reg(wb_reg), .q_count(q_count),
        .mem_vld(mem_vld), .mem_instr(mem_instr), .alu_vld(alu_vld),
        .alu_instr(alu_instr), .mul_vld(mul_vld), .mul_instr(mul_instr)
    );

    int n_run = 0, n_fail = 0;
    logic [W-1:0] prog [QD];

    function automatic logic [W-1:0] mk(int cls, bit st, bit dv, int d,
                                        bit v1, int s1, bit v2, int s2, int tag);
        return {2'(cls), st, dv, 5'(d), v1, 5'(s1), v2, 5'(s2), 6'(tag)};
    endfunction

    function automatic logic [7:0] cls_mask(int c);
        logic [7:0] m = '0;
        logic [OQ-1:0] v = (c == 0) ? mem_vld : (c == 1) ? alu_vld : mul_vld;
        logic [OQ*W-1:0] d = (c == 0) ? mem_instr : (c == 1) ? alu_instr : mul_instr;
        for (int k = 0; k < OQ; k++)
            if (v[k]) m[d[k*W +: 3]] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] all_mask();
        return cls_mask(0) | cls_mask(1) | cls_mask(2);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_cnt = '0; in_instr = '0; wb_vld = '0; wb_reg = '0;
        occ_mem = 2'd2; occ_alu = 2'd2; occ_mul = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(int n);
        occ_mem = 2'd2; occ_alu = 2'd2; occ_mul = 2'd2;
        for (int b = 0; b < n; b += FW) begin
            in_cnt = 3'((n - b > FW) ? FW : n - b);
            for (int k = 0; k < FW; k++)
                in_instr[k*W +: W] = (b + k < n) ? prog[b+k] : '0;
            @(negedge clk);
        end
        in_cnt = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check("R1", "count after reset", int'(q_count), 0);
        check("R1", "slots after reset", int'({mem_vld, alu_vld, mul_vld}), 0);

        // R3/R10 sweep: every class against every occupancy with a full queue
        for (int c = 0; c < 3; c++) begin
            for (int o = 0; o < 3; o++) begin
                do_reset();
                for (int i = 0; i < QD; i++) prog[i] = mk(c, 0, 1, 16 + i, 1, 1, 0, 0, i);
                load(QD);
                #1 check("R1", "count after fill", int'(q_count), 8);
                if (c == 0) occ_mem = 2'(o);
                else if (c == 1) occ_alu = 2'(o);
                else occ_mul = 2'(o);
                #1;
                check("R3", "class cap oldest first", int'(cls_mask(c)), (1 << (2 - o)) - 1);
                check("R2", "only own class slots", int'(all_mask()), (1 << (2 - o)) - 1);
                @(negedge clk); #1;
                check("R10", "count after removal", int'(q_count), 8 - (2 - o));
                if (o == 0) check("R10", "next oldest after shift", int'(cls_mask(c)), 8'h0C);
            end
        end

        // R3: six at once across classes, R2 routing
        do_reset();
        prog[0] = mk(0,0,1,16,1,1,0,0,0); prog[1] = mk(0,0,1,17,1,1,0,0,1);
        prog[2] = mk(1,0,1,18,1,1,0,0,2); prog[3] = mk(1,0,1,19,1,1,0,0,3);
        prog[4] = mk(2,0,1,20,1,1,0,0,4); prog[5] = mk(2,0,1,21,1,1,0,0,5);
        prog[6] = mk(1,0,1,22,1,1,0,0,6); prog[7] = mk(1,0,1,23,1,1,0,0,7);
        load(8);
        occ_mem = 0; occ_alu = 0; occ_mul = 0; #1;
        check("R3", "six issued", int'(all_mask()), 8'h3F);
        check("R2", "memory routing", int'(cls_mask(0)), 8'h03);
        check("R2", "alu routing", int'(cls_mask(1)), 8'h0C);
        check("R2", "mul routing", int'(cls_mask(2)), 8'h30);

        // R2: class code 3 never issues
        do_reset();
        prog[0] = mk(3,0,1,5,1,1,0,0,0); prog[1] = mk(1,0,1,6,1,2,0,0,1);
        load(2);
        occ_mem = 0; occ_alu = 0; occ_mul = 0; #1;
        check("R2", "class 3 held", int'(all_mask()), 8'h02);

        // R4: RAW against older entry
        do_reset();
        prog[0] = mk(1,0,1,5,1,1,0,0,0); prog[1] = mk(1,0,1,6,1,5,0,0,1);
        prog[2] = mk(1,0,1,7,1,1,1,2,2);
        load(3);
        occ_alu = 0; #1;
        check("R4", "raw older", int'(all_mask()), 8'h05);

        // R5: WAW against older entry
        do_reset();
        prog[0] = mk(1,0,1,5,1,1,0,0,0); prog[1] = mk(1,0,1,5,1,2,0,0,1);
        prog[2] = mk(2,0,1,6,1,1,0,0,2);
        load(3);
        occ_mem = 0; occ_alu = 0; occ_mul = 0; #1;
        check("R5", "waw older", int'(all_mask()), 8'h05);

        // R6: WAR against older entry
        do_reset();
        prog[0] = mk(1,0,1,3,1,9,0,0,0); prog[1] = mk(1,0,1,9,1,1,0,0,1);
        prog[2] = mk(1,0,1,10,1,1,0,0,2);
        load(3);
        occ_alu = 0; #1;
        check("R6", "war older", int'(all_mask()), 8'h05);

        // R7: pending set on issue, cleared one cycle after writeback
        do_reset();
        occ_alu = 0;
        in_cnt = 1; in_instr[0 +: W] = mk(1,0,1,5,1,1,0,0,0);
        @(negedge clk); in_cnt = 0; #1;
        check("R7", "producer issues", int'(all_mask()), 8'h01);
        in_cnt = 1; in_instr[0 +: W] = mk(1,0,1,6,1,5,0,0,1);
        @(negedge clk); in_cnt = 0; #1;
        check("R7", "consumer blocked by pending", int'(all_mask()), 8'h00);
        check("R10", "count after swap", int'(q_count), 1);
        wb_vld = 3'b001; wb_reg = 15'd5; #1;
        check("R7", "same-cycle clear not visible", int'(all_mask()), 8'h00);
        @(negedge clk); wb_vld = '0; #1;
        check("R7", "consumer issues after clear", int'(all_mask()), 8'h02);

        // R8: load next to older store
        do_reset();
        prog[0] = mk(0,1,0,0,1,1,1,2,0); prog[1] = mk(0,0,1,3,1,4,0,0,1);
        load(2);
        occ_mem = 0; #1;
        check("R8", "load joins older store", int'(all_mask()), 8'h03);
        occ_mem = 1; #1;
        check("R8", "load waits for store", int'(all_mask()), 8'h01);

        // R8 and R9: blocked store holds later load and later store
        do_reset();
        prog[0] = mk(1,0,1,7,1,1,0,0,0); prog[1] = mk(0,1,0,0,1,7,1,2,1);
        prog[2] = mk(0,0,1,3,1,4,0,0,2); prog[3] = mk(0,1,0,0,1,5,1,6,3);
        load(4);
        occ_mem = 0; occ_alu = 0; occ_mul = 0; #1;
        check("R8 R9", "blocked store holds memory ops", int'(all_mask()), 8'h01);

        // R9: store passes an older load
        do_reset();
        prog[0] = mk(0,0,1,3,1,4,0,0,0); prog[1] = mk(0,1,0,0,1,5,1,6,1);
        load(2);
        occ_mem = 1; #1;
        check("R9", "one slot takes oldest", int'(all_mask()), 8'h01);
        occ_mem = 0; #1;
        check("R9", "store beside older load", int'(all_mask()), 8'h03);

        // R10: compaction and slot order
        do_reset();
        prog[0] = mk(1,0,1,10,1,1,0,0,0); prog[1] = mk(2,0,1,11,1,1,0,0,1);
        prog[2] = mk(1,0,1,12,1,1,0,0,2); prog[3] = mk(2,0,1,13,1,1,0,0,3);
        load(4);
        occ_alu = 1; #1;
        check("R10", "single alu slot", int'(all_mask()), 8'h01);
        @(negedge clk); #1;
        check("R10", "count after one leaves", int'(q_count), 3);
        occ_alu = 2; occ_mul = 0; #1;
        check("R10", "mul slot0 older", int'(mul_instr[0 +: 3]), 1);
        check("R10", "mul slot1 younger", int'(mul_instr[W +: 3]), 3);
        @(negedge clk); #1;
        check("R10", "count after two leave", int'(q_count), 1);
        occ_alu = 0; #1;
        check("R10", "last entry shifted to head", int'(all_mask()), 8'h04);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule